// File: doc/BRIEF.md
# Strobed Byte Input Port with Handshake Flags

This block is an 8-bit peripheral input port that works in a strobed handshake mode. An external device places a byte on the port pins and pulls an active-low strobe. While the strobe is low, the block copies the pins into an internal holding register. When the strobe falls, the block raises a buffer-full flag. When the strobe rises, and only if the interrupt-enable bit is set, the block also raises an interrupt request to the host.

The host reads the held byte with an active-low read strobe. The falling edge of that read drops the interrupt request. The rising edge clears buffer-full. A separate select line turns the read into a status read, which returns the flags and does not disturb them. The interrupt-enable bit sits in a single-bit position of the companion control port. A bit set/reset command written on a synchronous write port changes it.

Both strobe inputs are asynchronous. Each passes through a two-flop synchronizer, and the block detects its edges in the system clock domain. Every timing rule below is therefore counted in clock edges.

Top module: `strobed_in_port`

## Requirements
- R1: A synchronous reset (active-high `rst`) clears the buffer-full flag, the interrupt request, the interrupt-enable bit and the held byte. A status read straight after reset returns 0x00.
- R2: `ibf` goes high at the third rising clock edge after `stb_n` goes low, and it is still low after the second.
- R3: After a data read (`rd_status`=0), `ibf` goes low at the third clock edge after `rd_n` returns high. It stays high while `rd_n` is still low.
- R4: When `stb_n` returns high while `ibf` is high and interrupt-enable is set, `intr` goes high at the third clock edge after the rising strobe, and not before.
- R5: While interrupt-enable is clear, `intr` stays low through any strobe.
- R6: `intr` goes low at the third clock edge after `rd_n` falls for a data read.
- R7: A read strobe that falls with `rd_status`=0 makes `rvalid` pulse for one cycle at the third clock edge after the fall, with `rdata` equal to the held byte. The held byte follows the pins while the synchronized strobe is low and keeps its last value after the strobe rises.
- R8: A write on `wr_en` with `wr_data[7]`=0 is a bit set/reset command: `wr_data[3:1]` selects a bit and `wr_data[0]` is the new value. Bit 4 (SIDE_B=0) or bit 2 (SIDE_B=1) is the interrupt-enable bit. Commands for other bits, and writes with `wr_data[7]`=1, leave interrupt-enable unchanged.
- R9: A read with `rd_status`=1 returns a status byte with buffer-full in bit 0, interrupt-enable in bit 1, interrupt request in bit 2 and zeros above, with the same `rvalid` timing as R7. A status read changes no flag.
- R10: A new strobe while `ibf` is high overwrites the held byte, and `ibf` and `intr` stay high.
- R11: Clearing interrupt-enable while `intr` is high drops `intr` at the clock edge after the write is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| port_pins | input | 8 | Byte from the external device |
| stb_n | input | 1 | Asynchronous strobe from the device, active low |
| rd_n | input | 1 | Asynchronous host read strobe, active low |
| rd_status | input | 1 | 1 selects the status byte for a read, 0 selects the data byte |
| wr_en | input | 1 | One-cycle control write qualifier |
| wr_data | input | 8 | Control write byte (bit set/reset command) |
| rdata | output | 8 | Read result, valid while rvalid is high |
| rvalid | output | 1 | One-cycle pulse that marks a read result |
| ibf | output | 1 | Buffer-full flag |
| intr | output | 1 | Interrupt request to the host |

## Verification
Every strobe-driven result is due three clock edges after the input edge: two synchronizer flops and one state register. The bench drives its inputs at falling clock edges and samples at the falling edge after exactly that many rising edges. Where a requirement states when a flag must not yet have moved, the bench also samples one edge earlier. Interrupt-enable changes one edge after a write is taken, and a dropped enable clears `intr` one edge later still. Read results go into a queue when the read is issued. A monitor takes them off the queue whenever `rvalid` is high, so every result must come out once, in order, and with the expected value.

// File: rtl/sip_pkg.sv
package sip_pkg;
    localparam int DATA_W     = 8;
    localparam int BIT_IDX_W  = 3;
    // status byte bit positions
    localparam int ST_IBF_BIT  = 0;
    localparam int ST_INTE_BIT = 1;
    localparam int ST_INTR_BIT = 2;
    // bit set/reset command fields
    localparam int CMD_TYPE_BIT = 7;
    localparam int CMD_IDX_LO   = 1;
    localparam int CMD_VAL_BIT  = 0;

    typedef struct packed {
        logic [DATA_W-1:0] held;
        logic              ibf;
        logic              intr;
        logic              rd_data;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } core_state_t;
endpackage

// File: rtl/sip_sync.sv
module sip_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{IDLE}};
            prev_q  <= IDLE;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/sip_ctrl.sv
module sip_ctrl
    import sip_pkg::*;
#(
    parameter int INTE_POS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              inte
);
    logic inte_d, inte_q;
    logic unused_cmd_bits;

    assign unused_cmd_bits = ^wr_data[DATA_W-2:CMD_IDX_LO+BIT_IDX_W];

    always_comb begin
        inte_d = inte_q;
        if (wr_en && !wr_data[CMD_TYPE_BIT] &&
            (wr_data[CMD_IDX_LO +: BIT_IDX_W] == BIT_IDX_W'(INTE_POS)))
            inte_d = wr_data[CMD_VAL_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) inte_q <= 1'b0;
        else     inte_q <= inte_d;
    end

    assign inte = inte_q;

    // R8: without a write the enable bit cannot move
    p_inte_keep_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(inte_q));
endmodule

// File: rtl/sip_core.sv
module sip_core
    import sip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] pins,
    input  logic              stb_low,
    input  logic              stb_fall,
    input  logic              stb_rise,
    input  logic              rd_low,
    input  logic              rd_fall,
    input  logic              rd_rise,
    input  logic              rd_status,
    input  logic              inte,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              ibf,
    output logic              intr
);
    core_state_t st_d, st_q;
    logic [DATA_W-1:0] status_byte;

    always_comb begin
        status_byte              = '0;
        status_byte[ST_IBF_BIT]  = st_q.ibf;
        status_byte[ST_INTE_BIT] = inte;
        status_byte[ST_INTR_BIT] = st_q.intr;
    end

    always_comb begin
        st_d = st_q;
        // holding register follows pins while the strobe is low
        if (stb_low) st_d.held = pins;
        // buffer-full: strobe fall sets, end of data read clears; set wins
        if (stb_fall)                      st_d.ibf = 1'b1;
        else if (rd_rise && st_q.rd_data)  st_d.ibf = 1'b0;
        // interrupt request
        if (!inte)                         st_d.intr = 1'b0;
        else if (stb_rise && st_q.ibf)     st_d.intr = 1'b1;
        else if (rd_fall && !rd_status)    st_d.intr = 1'b0;
        // remember the kind of the read in progress
        if (rd_fall)                       st_d.rd_data = !rd_status;
        else if (!rd_low && !rd_rise)      st_d.rd_data = 1'b0;
        // read result
        st_d.rvalid = rd_fall;
        if (rd_fall) st_d.rdata = rd_status ? status_byte : st_q.held;
        else         st_d.rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;
    assign ibf    = st_q.ibf;
    assign intr   = st_q.intr;

    p_ibf_set_r2: assert property (@(posedge clk) disable iff (rst)
        stb_fall |=> st_q.ibf);
    p_ibf_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && st_q.rd_data && !stb_fall) |=> !st_q.ibf);
    p_intr_set_r4: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && inte && st_q.ibf) |=> st_q.intr);
    p_intr_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_fall && !rd_status && !stb_rise) |=> !st_q.intr);
    p_rvalid_r7: assert property (@(posedge clk) disable iff (rst)
        rd_fall |=> st_q.rvalid);
    p_intr_gate_r11: assert property (@(posedge clk) disable iff (rst)
        !inte |=> !st_q.intr);
endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port
    import sip_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit SIDE_B      = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] port_pins,
    input  logic              stb_n,
    input  logic              rd_n,
    input  logic              rd_status,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              ibf,
    output logic              intr
);
    localparam int INTE_POS = SIDE_B ? 2 : 4;
    localparam int N_SYNC   = 2;
    localparam int IDX_STB  = 0;
    localparam int IDX_RD   = 1;

    logic [N_SYNC-1:0] async_vec, lvl_vec, rise_vec, fall_vec;
    logic              inte;

    assign async_vec[IDX_STB] = stb_n;
    assign async_vec[IDX_RD]  = rd_n;

    for (genvar gi = 0; gi < N_SYNC; gi++) begin : g_sync
        sip_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (async_vec[gi]),
            .level    (lvl_vec[gi]),
            .rise     (rise_vec[gi]),
            .fall     (fall_vec[gi])
        );
    end

    sip_ctrl #(.INTE_POS(INTE_POS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .inte    (inte)
    );

    sip_core u_core (
        .clk       (clk),
        .rst       (rst),
        .pins      (port_pins),
        .stb_low   (!lvl_vec[IDX_STB]),
        .stb_fall  (fall_vec[IDX_STB]),
        .stb_rise  (rise_vec[IDX_STB]),
        .rd_low    (!lvl_vec[IDX_RD]),
        .rd_fall   (fall_vec[IDX_RD]),
        .rd_rise   (rise_vec[IDX_RD]),
        .rd_status (rd_status),
        .inte      (inte),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .ibf       (ibf),
        .intr      (intr)
    );
endmodule

// File: tb/strobed_in_port_tb.sv
`timescale 1ns/1ps
module strobed_in_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] port_pins = 8'h00;
    logic       stb_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       rd_status = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rdata;
    logic       rvalid, ibf, intr;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int popped = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    strobed_in_port u_dut (
        .clk(clk), .rst(rst), .port_pins(port_pins), .stb_n(stb_n),
        .rd_n(rd_n), .rd_status(rd_status), .wr_en(wr_en), .wr_data(wr_data),
        .rdata(rdata), .rvalid(rvalid), .ibf(ibf), .intr(intr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_start(input bit st, input logic [7:0] exp);
        rd_status = st;
        rd_n = 1'b0;
        exp_q.push_back(exp);
        pushed++;
        cyc(3);
    endtask

    task automatic rd_end();
        rd_n = 1'b1;
        cyc(3);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_data = d;
        wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] d);
        port_pins = d;
        stb_n = 1'b0;
        cyc(4);
        stb_n = 1'b1;
        cyc(3);
    endtask

    // monitor: scoreboard for read results (R7, R9)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rvalid) begin
                popped++;
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected rvalid", 8'h01, 8'h00);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk("R7/R9 read data", rdata, e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 ibf after reset", {7'b0, ibf}, 8'h00);
        chk("R1 intr after reset", {7'b0, intr}, 8'h00);
        chk("R1 rvalid after reset", {7'b0, rvalid}, 8'h00);
        rd_start(1'b1, 8'h00);
        rd_end();

        // R2 buffer-full timing, R5 with enable clear
        port_pins = 8'hA5;
        stb_n = 1'b0;
        cyc(2);
        chk("R2 ibf not yet after 2 edges", {7'b0, ibf}, 8'h00);
        cyc(1);
        chk("R2 ibf after 3 edges", {7'b0, ibf}, 8'h01);
        cyc(2);
        stb_n = 1'b1;
        cyc(3);
        chk("R5 intr stays low, enable clear", {7'b0, intr}, 8'h00);
        rd_start(1'b0, 8'hA5);
        chk("R3 ibf held while rd_n low", {7'b0, ibf}, 8'h01);
        rd_end();
        chk("R3 ibf cleared after read", {7'b0, ibf}, 8'h00);

        // R8 set enable (bit 4): 0_000_100_1
        wr(8'h09);
        rd_start(1'b1, 8'h02);
        rd_end();

        // R4 interrupt timing
        port_pins = 8'h3C;
        stb_n = 1'b0;
        cyc(4);
        stb_n = 1'b1;
        cyc(2);
        chk("R4 intr not yet after 2 edges", {7'b0, intr}, 8'h00);
        cyc(1);
        chk("R4 intr after 3 edges", {7'b0, intr}, 8'h01);
        // R9 status read leaves flags alone
        rd_start(1'b1, 8'h07);
        rd_end();
        chk("R9 ibf after status read", {7'b0, ibf}, 8'h01);
        chk("R9 intr after status read", {7'b0, intr}, 8'h01);

        // R10 overwrite while full
        port_pins = 8'hC3;
        stb_n = 1'b0;
        cyc(4);
        chk("R10 ibf stays high", {7'b0, ibf}, 8'h01);
        stb_n = 1'b1;
        cyc(3);
        chk("R10 intr stays high", {7'b0, intr}, 8'h01);
        rd_start(1'b0, 8'hC3);
        chk("R6 intr low after read fall", {7'b0, intr}, 8'h00);
        rd_end();
        chk("R3 ibf low after second read", {7'b0, ibf}, 8'h00);

        // R8 ignored writes: mode byte, bit 2, bit 5
        wr(8'h88);
        wr(8'h04);
        wr(8'h0A);
        rd_start(1'b1, 8'h02);
        rd_end();

        // R8 clear enable, R5 strobe without interrupt
        wr(8'h08);
        strobe(8'h5A);
        chk("R5 intr low with enable clear", {7'b0, intr}, 8'h00);
        chk("R2 ibf high after strobe", {7'b0, ibf}, 8'h01);
        rd_start(1'b1, 8'h01);
        rd_end();
        rd_start(1'b0, 8'h5A);
        rd_end();

        // R11 dropping enable drops intr
        wr(8'h09);
        strobe(8'h77);
        chk("R4 intr high before disable", {7'b0, intr}, 8'h01);
        wr(8'h08);
        cyc(1);
        chk("R11 intr low after disable", {7'b0, intr}, 8'h00);
        rd_start(1'b0, 8'h77);
        rd_end();

        // R7 holding register follows pins while low, then holds
        port_pins = 8'h11;
        stb_n = 1'b0;
        cyc(3);
        port_pins = 8'h22;
        cyc(3);
        stb_n = 1'b1;
        cyc(3);
        port_pins = 8'h99;
        cyc(2);
        rd_start(1'b0, 8'h22);
        rd_end();

        cyc(2);
        chk("R7 all reads returned", 8'(popped), 8'(pushed));
        chk("R7 queue empty", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule